// File: doc/BRIEF.md
# NRZI framed serial transmitter

This block serializes framed packets onto a single-wire link. Each frame is a run of three 1 bits that marks the start, then a 16-bit header, then a payload of 16-bit words. The header carries a 4-bit packet type and a 12-bit word count. Logical bits go onto the wire in NRZI form: a 1 flips the line level and a 0 leaves it alone. After six logical zeros in a row, the encoder forces an extra 1 into the stream. This keeps the line toggling often enough for a receiver that has no clock of its own to stay locked.

The bit rate is set from outside by a one-cycle strobe, `bit_en`, and each strobe carries exactly one line bit. At 20 Mbps from a 40 MHz clock the strobe is high every second cycle. The strobe may also be high every cycle, or follow any irregular pattern.

A frame is offered on a header handshake. Its payload words then follow on a word handshake. Both ready signals are combinational and appear only in a strobe cycle. When no frame is pending, the line carries logical zeros. Because stuffing still applies to those zeros, an idle line flips once every seven bit slots.

Top module: `nrzi_frame_tx`

## Requirements
- R1: After reset the line output is 0 and `wd_ready` is low. The encoder starts idle with a cleared zero-run count.
- R2: In a bit slot, a logical 1 inverts `line_out` and a logical 0 keeps it. The new level appears after the clock edge at which `bit_en` was high.
- R3: After six consecutive logical 0 bits, the next slot carries an inserted logical 1. Any 1, whether data or inserted, clears the zero-run count. The rule applies equally to idle, sync, header and payload bits.
- R4: With no frame offered, the line carries zeros and toggles in every seventh slot, counting slots from reset, and in no other slot.
- R5: A header is accepted (`hdr_valid` and `hdr_ready` high in a strobe cycle) in the very slot that carries the first of three sync bits, all of which are logical 1.
- R6: The 16 header bits follow the sync, most significant bit first. Bits 15:12 hold `hdr_type` and bits 11:0 hold `hdr_len`.
- R7: Exactly `hdr_len` payload words follow the header, each sent most significant bit first. Each word is accepted in the slot that carries its bit 15. A length of 0 gives a frame with no payload.
- R8: Neither ready signal is high in a slot taken by an inserted 1, and no input is consumed in that slot.
- R9: A header held valid is accepted in the first non-inserted slot after the previous frame's last bit. Back-to-back frames therefore have no idle zeros between them.
- R10: `line_out` does not change in any cycle without `bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe; one line bit per high cycle |
| hdr_valid | input | 1 | A frame header is offered |
| hdr_ready | output | 1 | Header taken at this edge (strobe cycle, encoder idle, no inserted bit) |
| hdr_type | input | 4 | Packet type, placed in header bits 15:12 |
| hdr_len | input | 12 | Payload length in 16-bit words, placed in header bits 11:0 |
| wd_valid | input | 1 | A payload word is offered; if low when a word is due, the slot carries a 0 and the request repeats |
| wd_ready | output | 1 | Payload word taken at this edge |
| wd_data | input | 16 | Payload word |
| line_out | output | 1 | NRZI-coded line level |

## Verification
The bench recovers logical bits from the line's transitions, removes inserted bits, and reparses every frame against what it offered.

- **All-zero header.** A type-0, length-0 frame gives a header that is entirely zeros and forces stuffing inside it. A design that stuffs only payload would emit seven or more zeros in a row.
- **Zero payload word.** A zero word exposes a design that does not clear its run count on an inserted 1: it would stuff at the wrong place or twice.
- **Handshake during an inserted slot.** Readies that stay high during such a slot would drop or duplicate a word or header. The bench flags this as a misaligned accept.
- **Frame spacing and strobe patterns.** Frames run back to back under every-second-cycle, random and every-cycle strobes. A design that idles between frames, or moves the line without a strobe, shows stray zeros or level changes.

// File: rtl/nrzi_frame_tx.sv
module nrzi_frame_tx #(
  parameter int TYPE_W  = 4,
  parameter int LEN_W   = 12,
  parameter int WORD_W  = 16,
  parameter int SYNC_W  = 3,
  parameter int RUN_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [TYPE_W-1:0] hdr_type,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [WORD_W-1:0] wd_data,
  output logic              line_out
);
  localparam int HIMG_W = SYNC_W - 1 + TYPE_W + LEN_W;
  localparam int SH_W   = (HIMG_W > WORD_W - 1) ? HIMG_W : WORD_W - 1;
  localparam int CNT_W  = $clog2(SH_W + 1);
  localparam int RUN_W  = $clog2(RUN_MAX + 1);

  logic [SH_W-1:0]   sh;
  logic [CNT_W-1:0]  left;
  logic [LEN_W-1:0]  words_left;
  logic [RUN_W-1:0]  zrun;
  logic [HIMG_W-1:0] hdr_img;
  logic              stuff, queued, owing, tx_bit;

  // remaining sync ones, then type and length; the first sync bit goes out in the accept slot
  assign hdr_img   = {{(SYNC_W-1){1'b1}}, hdr_type, hdr_len};
  assign stuff     = (zrun == RUN_W'(RUN_MAX));
  assign queued    = (left != '0);
  assign owing     = (words_left != '0);
  assign hdr_ready = bit_en && !stuff && !queued && !owing;
  assign wd_ready  = bit_en && !stuff && !queued && owing;

  always_comb begin
    if (stuff)       tx_bit = 1'b1;
    else if (queued) tx_bit = sh[SH_W-1];
    else if (owing)  tx_bit = wd_valid & wd_data[WORD_W-1];
    else             tx_bit = hdr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      left       <= '0;
      words_left <= '0;
      zrun       <= '0;
      line_out   <= 1'b0;
    end else if (bit_en) begin
      line_out <= line_out ^ tx_bit;
      zrun     <= tx_bit ? '0 : zrun + 1'b1;
      if (!stuff) begin
        if (queued) begin
          sh   <= sh << 1;
          left <= left - 1'b1;
        end else if (owing) begin
          if (wd_valid) begin
            sh         <= SH_W'(wd_data[WORD_W-2:0]) << (SH_W - (WORD_W - 1));
            left       <= CNT_W'(WORD_W - 1);
            words_left <= words_left - 1'b1;
          end
        end else if (hdr_valid) begin
          sh         <= SH_W'(hdr_img) << (SH_W - HIMG_W);
          left       <= CNT_W'(HIMG_W);
          words_left <= hdr_len;
        end
      end
    end
  end

  assert_line_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_out));

  assert_stuff_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && stuff |=> line_out != $past(line_out));

  assert_zero_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= RUN_W'(RUN_MAX));

  assert_sync_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> line_out != $past(line_out));

  assert_word_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid && wd_ready |=> (line_out ^ $past(line_out)) == $past(wd_data[WORD_W-1]));

  assert_quiet_stuff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> !stuff && !hdr_ready);
endmodule

// File: tb/nrzi_frame_tx_tb.sv
module nrzi_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int MAXW = 8;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
  logic hdr_valid = 1'b0, wd_valid = 1'b0;
  logic hdr_ready, wd_ready, line_out;
  logic [3:0] hdr_type = '0;
  logic [11:0] hdr_len = '0;
  logic [15:0] wd_data = '0;

  nrzi_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_type(hdr_type), .hdr_len(hdr_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .line_out(line_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  logic [3:0]  f_type [NF];
  logic [11:0] f_len  [NF];
  logic [15:0] f_data [NF][MAXW];

  int src_f = 0, data_f = -1, src_w = 0;
  bit allow = 0, pend_hdr = 0, pend_wd = 0, pend_rdy = 0, half = 0;
  int p_mode = 0, p_cnt = 0, p_frame = 0, p_word = 0, rx_len = 0;
  int rx_zrun = 0, idle_zeros = 0, slot_no = 0;
  bit started = 0;
  logic [15:0] p_sh = '0;
  logic last_line = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hdr_word(input int i);
    return {f_type[i], f_len[i]};
  endfunction

  task automatic end_frame();
    p_frame++;
    p_mode = 0;
    idle_zeros = 0;
  endtask

  task automatic rx_slot(input logic b, input bit acc_h, input bit acc_w, input bit rdy);
    if (rx_zrun == 6) begin
      chk(b == 1'b1, "R3", "inserted one after six zeros", int'(b), 1);
      chk(!rdy, "R8", "ready during inserted slot", int'(rdy), 0);
      rx_zrun = 0;
      return;
    end
    rx_zrun = b ? 0 : rx_zrun + 1;
    if (acc_h) chk(p_mode == 0 && b == 1'b1, "R5", "header accept not at first sync bit", p_mode, 0);
    if (acc_w) chk(p_mode == 3 && p_cnt % 16 == 0, "R7", "word accept not at its msb slot", p_cnt, 0);
    case (p_mode)
      0: begin
        if (b) begin
          if (started && p_frame < NF) chk(idle_zeros == 0, "R9", "idle zeros between frames", idle_zeros, 0);
          started = 1;
          p_mode = 1;
          p_cnt = 1;
        end else idle_zeros++;
      end
      1: begin
        chk(b == 1'b1, "R5", "sync bit", int'(b), 1);
        p_cnt++;
        if (p_cnt == 3) begin p_mode = 2; p_cnt = 0; end
      end
      2: begin
        p_sh = {p_sh[14:0], b};
        p_cnt++;
        if (p_cnt == 16) begin
          if (p_frame < NF) chk(p_sh == hdr_word(p_frame), "R6", "header word", int'(p_sh), int'(hdr_word(p_frame)));
          rx_len = int'(p_sh[11:0]);
          if (rx_len == 0) end_frame();
          else begin p_mode = 3; p_cnt = 0; p_word = 0; end
        end
      end
      default: begin
        p_sh = {p_sh[14:0], b};
        p_cnt++;
        if (p_cnt % 16 == 0) begin
          if (p_frame < NF && p_word < MAXW)
            chk(p_sh == f_data[p_frame][p_word], "R7", "payload word", int'(p_sh), int'(f_data[p_frame][p_word]));
          p_word++;
          if (p_word == rx_len) end_frame();
        end
      end
    endcase
  endtask

  initial begin
    int cyc = 0, tail = 0;
    logic nb;
    void'($urandom(32'd1234));
    for (int i = 0; i < NF; i++)
      for (int j = 0; j < MAXW; j++) f_data[i][j] = '0;
    f_type[0] = 4'h0; f_len[0] = 12'd0;
    f_type[1] = 4'hF; f_len[1] = 12'd1; f_data[1][0] = 16'h0000;
    f_type[2] = 4'h5; f_len[2] = 12'd3;
    f_data[2][0] = 16'hFFFF; f_data[2][1] = 16'h8001; f_data[2][2] = 16'h0040;
    for (int i = 3; i < NF; i++) begin
      f_type[i] = 4'($urandom_range(0, 15));
      f_len[i] = 12'($urandom_range(0, 4));
      for (int j = 0; j < MAXW; j++)
        f_data[i][j] = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom);
    end

    repeat (4) @(negedge clk);
    chk(line_out == 1'b0, "R1", "line level in reset", int'(line_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_out == 1'b0 && wd_ready == 1'b0, "R1", "state after reset", int'({line_out, wd_ready}), 0);

    forever begin
      @(negedge clk);
      cyc++;
      if (bit_en) begin
        nb = line_out ^ last_line;
        last_line = line_out;
        slot_no++;
        if (!allow) begin
          // idle: slot numbers counted from reset; every seventh one toggles
          if (slot_no % 7 == 0) chk(nb == 1'b1, "R4", "idle toggle in seventh slot", int'(nb), 1);
          else chk(nb == 1'b0, "R2", "idle zero keeps level", int'(nb), 0);
        end else rx_slot(nb, pend_hdr, pend_wd, pend_rdy);
        if (pend_hdr) begin data_f = src_f; src_w = 0; src_f++; end
        if (pend_wd) src_w++;
      end else begin
        chk(line_out == last_line, "R10", "line moved without strobe", int'(line_out), int'(last_line));
      end
      if (!allow && slot_no >= 42) allow = 1;

      half = !half;
      if (data_f < 3) bit_en = half;
      else if (data_f < 6) bit_en = 1'($urandom_range(0, 1));
      else bit_en = 1'b1;
      hdr_valid = allow && src_f < NF;
      if (src_f < NF) begin hdr_type = f_type[src_f]; hdr_len = f_len[src_f]; end
      wd_valid = 1'b0;
      wd_data = '0;
      if (data_f >= 0 && src_w < int'(f_len[data_f])) begin
        wd_valid = 1'b1;
        wd_data = f_data[data_f][src_w];
      end
      #1;
      pend_hdr = hdr_valid && hdr_ready;
      pend_wd = wd_valid && wd_ready;
      pend_rdy = hdr_ready || wd_ready;

      if (p_frame >= NF) tail++;
      if (tail > 60) break;
      if (cyc > 150000) begin
        chk(0, "watchdog", "run did not finish", cyc, 150000);
        break;
      end
    end
    chk(p_frame == NF, "R9", "frames received", p_frame, NF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule